// File: doc/BRIEF.md
# Command Strobe and Interrupt Latch

This block is the write-only command port of a data-acquisition peripheral. Every bit of a byte written over a simple register bus is a trigger, not stored data. Writing a 1 to a bit sends a single-clock pulse to the neighbouring logic. Writing a 0 does nothing. One write may fire any mix of actions, and they all fire together. The actions are a software conversion start, a board-wide register reset, a reset of the analog output channels, a FIFO fill-pointer clear, and clears for four latched interrupt requests.

The block also keeps the conversion-busy flag, which a reader sees as bit 7 of the status byte. It gates the start request by trigger mode: software in one mode, an external or timer trigger in the other. It holds one request flip-flop for each interrupt source (analog, digital I/O, timer, DMA). Each flip-flop stays set until software clears it. The combined interrupt line is the OR of the enabled flags. The converter, the FIFO, the analog outputs, DMA and the timers sit outside the block and connect only through pulse and event ports.

Top module: `cmd_strobe_ctrl`

## Requirements
- R1: Command bits map as follows: bit 7 start, bit 6 board reset, bit 5 analog-output reset, bit 4 FIFO reset, bits 3..0 clear the DMA, timer, digital-I/O and analog request flags. A write with a bit at 1 gives exactly one clock of the matching strobe in the cycle after the write is sampled. A bit at 0 gives no strobe.
- R2: When several bits are 1 in one write, all of their strobes appear in the same cycle.
- R3: With trigger mode 0 and busy low, a write with bit 7 set gives a one-cycle `start_o`, and `busy_o` is high in that same cycle.
- R4: With trigger mode 1, bit 7 is ignored and `hw_trig_i` starts a conversion instead, with the same timing. With trigger mode 0, `hw_trig_i` is ignored.
- R5: `busy_o` stays high until a `conv_done_i` pulse. It is low from the next cycle on. A start request, from either source, made while busy is high is ignored.
- R6: The board-reset strobe clears `busy_o` and all four request flags at the end of its cycle. It never asserts `dac_rst_o`, and a start request in its cycle is ignored.
- R7: An event on `irq_evt_i[i]` sets `irq_flags_o[i]` (index 0 analog, 1 digital I/O, 2 timer, 3 DMA) in the next cycle. The flag holds until the clear strobe from command bit i clears it. While it is set, further events leave it unchanged.
- R8: If an event and the clear strobe for the same source fall in the same cycle, the flag stays set.
- R9: `irq_o` is high exactly when some flag i is set and `irq_en_i[i]` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Command write strobe |
| wdata_i | input | 8 | Command byte |
| hw_trig_mode_i | input | 1 | 1 selects the hardware trigger; 0 selects the software start |
| hw_trig_i | input | 1 | External or timer trigger pulse |
| conv_done_i | input | 1 | Conversion complete pulse |
| irq_evt_i | input | 4 | Interrupt events (0 analog, 1 DIO, 2 timer, 3 DMA) |
| irq_en_i | input | 4 | Per-source interrupt enables |
| start_o | output | 1 | Conversion start pulse |
| board_rst_o | output | 1 | Board register reset pulse |
| dac_rst_o | output | 1 | Analog-output reset pulse |
| fifo_rst_o | output | 1 | FIFO pointer clear pulse |
| busy_o | output | 1 | Conversion busy (status bit 7) |
| irq_flags_o | output | 4 | Latched request flags |
| irq_o | output | 1 | Combined interrupt line |

## Verification
Two pairs of functions can fall in the same cycle. The first is an interrupt event arriving while that source's clear strobe is high. The bench provokes this with a directed clear write followed by an event placed in the strobe cycle, and the flag must survive. The second is a start request meeting a busy flag or a board-reset strobe. The bench provokes this by writing bit 7 during a conversion and by combining bits 7 and 6. Random traffic with a fixed seed then mixes writes, triggers, done pulses and events, and a cycle-level model built from the requirements judges every output on each cycle.

// File: rtl/cmd_strobe_pkg.sv
package cmd_strobe_pkg;
  localparam int unsigned CMD_W     = 8;
  localparam int unsigned N_IRQ     = 4;
  localparam int unsigned BIT_START = 7;
  localparam int unsigned BIT_BRD   = 6;
  localparam int unsigned BIT_DAC   = 5;
  localparam int unsigned BIT_FIFO  = 4;

  typedef enum logic [1:0] {
    IRQ_ANA = 2'd0,
    IRQ_DIO = 2'd1,
    IRQ_TMR = 2'd2,
    IRQ_DMA = 2'd3
  } irq_src_e;
endpackage

// File: rtl/cmd_strobe_reg.sv
module cmd_strobe_reg
  import cmd_strobe_pkg::*;
#(
  parameter int unsigned W  = CMD_W,
  parameter int unsigned NI = N_IRQ
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic          start_fire_i,
  output logic          start_o,
  output logic          brd_o,
  output logic          dac_o,
  output logic          fifo_o,
  output logic [NI-1:0] clr_o
);
  logic [W-1:0] hit;
  assign hit = wr_i ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_o <= 1'b0;
      brd_o   <= 1'b0;
      dac_o   <= 1'b0;
      fifo_o  <= 1'b0;
      clr_o   <= '0;
    end else begin
      start_o <= start_fire_i;
      brd_o   <= hit[BIT_BRD];
      dac_o   <= hit[BIT_DAC];
      fifo_o  <= hit[BIT_FIFO];
      clr_o   <= hit[NI-1:0];
    end
  end
endmodule

// File: rtl/conv_busy_flag.sv
module conv_busy_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic done_i,
  input  logic kill_i,
  output logic busy_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     busy_o <= 1'b0;
    else if (kill_i) busy_o <= 1'b0;
    else if (set_i)  busy_o <= 1'b1;
    else if (done_i) busy_o <= 1'b0;
  end
endmodule

// File: rtl/irq_req_latch.sv
module irq_req_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic evt_i,
  input  logic clr_i,
  input  logic kill_i,
  output logic flag_o
);
  // event outranks clear so a request is never dropped
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_o <= 1'b0;
    else if (kill_i) flag_o <= 1'b0;
    else if (evt_i)  flag_o <= 1'b1;
    else if (clr_i)  flag_o <= 1'b0;
  end
endmodule

// File: rtl/cmd_strobe_ctrl.sv
module cmd_strobe_ctrl
  import cmd_strobe_pkg::*;
#(
  parameter int unsigned W     = CMD_W,
  parameter int unsigned N_IRQ = cmd_strobe_pkg::N_IRQ
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [W-1:0]     wdata_i,
  input  logic             hw_trig_mode_i,
  input  logic             hw_trig_i,
  input  logic             conv_done_i,
  input  logic [N_IRQ-1:0] irq_evt_i,
  input  logic [N_IRQ-1:0] irq_en_i,
  output logic             start_o,
  output logic             board_rst_o,
  output logic             dac_rst_o,
  output logic             fifo_rst_o,
  output logic             busy_o,
  output logic [N_IRQ-1:0] irq_flags_o,
  output logic             irq_o
);
  logic             sw_req, hw_req, start_fire;
  logic [N_IRQ-1:0] clr;

  assign sw_req     = wr_i & wdata_i[BIT_START] & ~hw_trig_mode_i;
  assign hw_req     = hw_trig_mode_i & hw_trig_i;
  assign start_fire = (sw_req | hw_req) & ~busy_o & ~board_rst_o;

  cmd_strobe_reg #(.W(W), .NI(N_IRQ)) i_reg (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_i         (wr_i),
    .wdata_i      (wdata_i),
    .start_fire_i (start_fire),
    .start_o      (start_o),
    .brd_o        (board_rst_o),
    .dac_o        (dac_rst_o),
    .fifo_o       (fifo_rst_o),
    .clr_o        (clr)
  );

  conv_busy_flag i_busy (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (start_fire),
    .done_i (conv_done_i),
    .kill_i (board_rst_o),
    .busy_o (busy_o)
  );

  for (genvar i = 0; i < N_IRQ; i++) begin : g_irq
    irq_req_latch i_lat (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .evt_i  (irq_evt_i[i]),
      .clr_i  (clr[i]),
      .kill_i (board_rst_o),
      .flag_o (irq_flags_o[i])
    );
  end

  assign irq_o = |(irq_flags_o & irq_en_i);
endmodule

// File: rtl/cmd_strobe_chk.sv
module cmd_strobe_chk #(
  parameter int unsigned W     = 8,
  parameter int unsigned N_IRQ = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_i,
  input logic [W-1:0]     wdata_i,
  input logic             hw_trig_mode_i,
  input logic             hw_trig_i,
  input logic             conv_done_i,
  input logic [N_IRQ-1:0] irq_evt_i,
  input logic [N_IRQ-1:0] irq_en_i,
  input logic             start_o,
  input logic             board_rst_o,
  input logic             dac_rst_o,
  input logic             fifo_rst_o,
  input logic             busy_o,
  input logic [N_IRQ-1:0] irq_flags_o,
  input logic             irq_o
);
  assert_fifo_strobe_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && wdata_i[4]) |=> fifo_rst_o);
  assert_no_idle_strobe_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> (!board_rst_o && !dac_rst_o && !fifo_rst_o));
  assert_start_single_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o);
  assert_start_busy_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> busy_o);
  assert_hw_mode_gate_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hw_trig_mode_i && !hw_trig_i) |=> !start_o);
  assert_busy_ignore_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> !start_o);
  assert_brd_keeps_dac_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && wdata_i[6] && !wdata_i[5]) |=> (board_rst_o && !dac_rst_o));
  assert_brd_clears_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    board_rst_o |=> (!busy_o && irq_flags_o == '0));
  assert_irq_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_flags_o == '0) |-> !irq_o);

  for (genvar i = 0; i < N_IRQ; i++) begin : g_chk
    assert_flag_set_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (irq_evt_i[i] && !board_rst_o) |=> irq_flags_o[i]);
  end
endmodule

bind cmd_strobe_ctrl cmd_strobe_chk #(.W(W), .N_IRQ(N_IRQ)) i_chk (.*);

// File: tb/test_cmd_strobe_ctrl.sv
module test_cmd_strobe_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr = 1'b0;
  logic [7:0] wd = '0;
  logic       mode = 1'b0, trig = 1'b0, done = 1'b0;
  logic [3:0] evt = '0, en = '0;
  logic       start_o, board_rst_o, dac_rst_o, fifo_rst_o, busy_o, irq_o;
  logic [3:0] flags_o;

  int unsigned total = 0, bad = 0;
  bit          finished = 1'b0;

  always #10 clk = ~clk;

  cmd_strobe_ctrl i_cmd_strobe_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .wdata_i(wd),
    .hw_trig_mode_i(mode), .hw_trig_i(trig), .conv_done_i(done),
    .irq_evt_i(evt), .irq_en_i(en),
    .start_o(start_o), .board_rst_o(board_rst_o), .dac_rst_o(dac_rst_o),
    .fifo_rst_o(fifo_rst_o), .busy_o(busy_o), .irq_flags_o(flags_o), .irq_o(irq_o)
  );

  // cycle model built from the requirements
  logic       m_start, m_brd, m_dac, m_fifo, m_busy;
  logic [3:0] m_clr, m_flags;

  function automatic logic fire_f(logic w, logic [7:0] d, logic md, logic tg,
                                  logic bz, logic br);
    return ((w & d[7] & ~md) | (md & tg)) & ~bz & ~br;
  endfunction

  function automatic logic [3:0] flags_f(logic [3:0] f, logic [3:0] e,
                                         logic [3:0] c, logic br);
    return br ? 4'h0 : (e | (f & ~c));
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_start <= 0; m_brd <= 0; m_dac <= 0; m_fifo <= 0;
      m_busy <= 0; m_clr <= 0; m_flags <= 0;
    end else begin
      logic f;
      f = fire_f(wr, wd, mode, trig, m_busy, m_brd);
      m_start <= f;
      m_brd   <= wr & wd[6];
      m_dac   <= wr & wd[5];
      m_fifo  <= wr & wd[4];
      m_clr   <= wr ? wd[3:0] : 4'h0;
      m_busy  <= m_brd ? 1'b0 : f ? 1'b1 : done ? 1'b0 : m_busy;
      m_flags <= flags_f(m_flags, evt, m_clr, m_brd);
    end
  end

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R3 start_o", {7'b0, start_o}, {7'b0, m_start});
      chk("R1 board_rst_o", {7'b0, board_rst_o}, {7'b0, m_brd});
      chk("R1 dac_rst_o", {7'b0, dac_rst_o}, {7'b0, m_dac});
      chk("R1 fifo_rst_o", {7'b0, fifo_rst_o}, {7'b0, m_fifo});
      chk("R5 busy_o", {7'b0, busy_o}, {7'b0, m_busy});
      chk("R7 irq_flags_o", {4'b0, flags_o}, {4'b0, m_flags});
      chk("R9 irq_o", {7'b0, irq_o}, {7'b0, |(m_flags & en)});
    end
  end

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic write(logic [7:0] d);
    wr = 1'b1; wd = d;
    step();
    wr = 1'b0; wd = '0;
  endtask

  initial begin
    #4_000_000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) step();
    chk("R1 reset strobes", {4'b0, start_o, board_rst_o, dac_rst_o, fifo_rst_o}, 8'h0);
    chk("R5 reset busy", {7'b0, busy_o}, 8'h0);
    rst_n = 1'b1;
    step();

    write(8'h10);
    chk("R1 fifo pulse", {7'b0, fifo_rst_o}, 8'h1);
    chk("R1 others quiet", {5'b0, start_o, board_rst_o, dac_rst_o}, 8'h0);
    step();
    chk("R1 fifo one clock", {7'b0, fifo_rst_o}, 8'h0);

    write(8'h30);
    chk("R2 dac+fifo together", {6'b0, dac_rst_o, fifo_rst_o}, 8'h3);
    step();

    write(8'h80);
    chk("R3 start pulse", {6'b0, start_o, busy_o}, 8'h3);
    step();
    chk("R3 start one clock", {6'b0, start_o, busy_o}, 8'h1);
    write(8'h80);
    chk("R5 start while busy ignored", {7'b0, start_o}, 8'h0);
    done = 1'b1; step(); done = 1'b0;
    chk("R5 done clears busy", {7'b0, busy_o}, 8'h0);

    mode = 1'b1;
    write(8'h80);
    chk("R4 sw start ignored in hw mode", {6'b0, start_o, busy_o}, 8'h0);
    trig = 1'b1; step(); trig = 1'b0;
    chk("R4 hw trigger starts", {6'b0, start_o, busy_o}, 8'h3);
    done = 1'b1; step(); done = 1'b0;
    mode = 1'b0;
    trig = 1'b1; step(); trig = 1'b0;
    chk("R4 hw trigger ignored in sw mode", {7'b0, start_o}, 8'h0);

    en = 4'hF;
    evt = 4'b0100; step(); evt = '0;
    chk("R7 timer flag set", {4'b0, flags_o}, 8'h4);
    chk("R9 irq high", {7'b0, irq_o}, 8'h1);
    en = 4'b1011; #1;
    chk("R9 irq masked", {7'b0, irq_o}, 8'h0);
    en = 4'hF;
    write(8'h04);
    evt = 4'b0100; step(); evt = '0;
    chk("R8 event beats clear", {4'b0, flags_o}, 8'h4);
    write(8'h04); step();
    chk("R7 clear drops flag", {4'b0, flags_o}, 8'h0);

    evt = 4'hF; step(); evt = '0;
    write(8'h80);
    write(8'h40);
    chk("R6 board reset keeps dac", {6'b0, board_rst_o, dac_rst_o}, 8'h2);
    step();
    chk("R6 flags and busy cleared", {3'b0, busy_o, flags_o}, 8'h0);

    write(8'hC0);
    chk("R2 start+board together", {6'b0, start_o, board_rst_o}, 8'h3);
    step();
    chk("R6 busy killed", {7'b0, busy_o}, 8'h0);

    for (int n = 0; n < 4000; n++) begin
      wr   = ($urandom_range(0, 9) < 3);
      wd   = 8'($urandom);
      if ($urandom_range(0, 99) < 3) mode = ~mode;
      trig = ($urandom_range(0, 9) == 0);
      done = ($urandom_range(0, 9) < 2);
      evt  = 4'($urandom) & 4'($urandom) & 4'($urandom);
      if ($urandom_range(0, 49) == 0) en = 4'($urandom);
      step();
    end
    wr = 0; wd = 0; trig = 0; done = 0; evt = 0;
    step();

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule